// File: doc/BRIEF.md
# Message-Buffer Interrupt Flag Controller

This block keeps one sticky completion flag per message buffer of a CAN-style controller. A buffer that finishes a frame, sent or received, raises a one-cycle event strobe, and the matching flag is latched. Software sees the flags through a small register port. It clears a flag by writing a 1 to its bit. A mask register chooses which flags drive the single interrupt line. With transmit abort enabled, a pending flag on a transmit buffer produces a per-buffer signal that the buffer RAM uses to reject CPU writes.

When receive-FIFO operation is switched on, the low eight flags take on new meanings. A counter follows the occupancy of the six-entry FIFO from push and pop strobes. Bit 7 reports a lost frame, bit 6 reports that the FIFO is nearly full, and bit 5 reports that at least one frame is waiting. Bits 4 to 0 stay at zero.

Top module: `mbif_irq_ctrl`

## Requirements
- R1: After reset the flag register, the mask register, `irq` and `wr_block` are all zero.
- R2: A 1 on `buf_event[i]` sets flag i, and the flag is readable at byte offset 0x30 after the next clock edge. In FIFO mode this holds only for bits 31 to 8.
- R3: A write to offset 0x30 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When a set and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R5: The mask register is written and read at offset 0x28. `irq` is 1 exactly when some bit is 1 in both the flags and the mask.
- R6: `wr_block[i]` is 1 exactly when `abort_en` is 1, `buf_is_tx[i]` is 1 and flag i is set. In FIFO mode bits 7 to 0 of `wr_block` are 0.
- R7: In FIFO mode, flag bits 4 to 0 read as 0, and buffer events on bits 7 to 0 have no effect.
- R8: In FIFO mode, bit 5 is set in every cycle that follows an edge leaving the FIFO non-empty, so a write-1 clear does not remove it while frames remain.
- R9: In FIFO mode, bit 6 is set when a push without a pop takes the occupancy from 4 to 5.
- R10: In FIFO mode, a push without a pop while the occupancy is 6 sets bit 7, and the occupancy stays at 6.
- R11: A push and a pop in the same cycle leave the occupancy unchanged and never set bit 7.
- R12: A write to any offset other than 0x28 or 0x30 changes nothing, and a read from such an offset returns 0.
- R13: While FIFO mode is off the occupancy is held at 0, and bits 7 to 0 act as ordinary buffer flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fifo_en | input | 1 | Receive-FIFO mode on |
| abort_en | input | 1 | Transmit abort mode on |
| buf_event | input | 32 | Per-buffer completion strobes |
| buf_is_tx | input | 32 | Per-buffer transmit configuration |
| fifo_push | input | 1 | Frame arriving at the receive FIFO |
| fifo_pop | input | 1 | Frame taken from the receive FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined masked interrupt |
| wr_block | output | 32 | Per-buffer CPU write block |

## Verification
The flag logic is driven with sparse multi-bit event words, all-zero and all-one clear words, and a clear that lands in the same cycle as an event. These patterns separate write-one-to-clear behaviour from plain writes, and show which of set and clear wins a collision. The FIFO tracker is filled past full with single pushes and then given a combined push and pop at full, which distinguishes saturation from wraparound and a correct simultaneous update from one treated as a push. Mode changes with frames still queued show whether the occupancy is discarded on leaving FIFO mode and whether the unused low bits are forced to zero.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  localparam int ADDR_W    = 6;
  localparam logic [ADDR_W-1:0] FLAG_OFS = 6'h30;
  localparam logic [ADDR_W-1:0] MASK_OFS = 6'h28;
  localparam int OVF_BIT   = 7;
  localparam int WARN_BIT  = 6;
  localparam int AVAIL_BIT = 5;
  localparam int FIFO_LOW  = 8;  // flags owned by FIFO mode
  localparam int DEAD_TOP  = 4;  // bits DEAD_TOP..0 unused in FIFO mode

  typedef struct packed {
    logic ovf;
    logic warn;
    logic avail;
  } fifo_evt_t;
endpackage

// File: rtl/mbif_rst_sync.sv
module mbif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbif_fifo_track.sv
module mbif_fifo_track
  import mbif_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WARN  = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      push,
  input  logic      pop,
  output fifo_evt_t evt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WARN_PRE = CNT_W'(WARN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             push_only, pop_only;

  assign push_only = push && !pop;
  assign pop_only  = pop && !push;

  always_comb begin
    cnt_d = cnt_q;
    evt   = '0;
    if (!fifo_en) begin
      cnt_d = '0;
    end else begin
      if (push_only) begin
        if (cnt_q == FULL) evt.ovf = 1'b1;
        else               cnt_d   = cnt_q + 1'b1;
      end else if (pop_only && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
      evt.warn  = push_only && (cnt_q == WARN_PRE);
      evt.avail = (cnt_d != '0);
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: occupancy never passes the FIFO depth
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R10: an overflow leaves the FIFO full
  a_r10_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ovf |=> cnt_q == FULL);
  // R11: a combined push and pop holds the occupancy
  a_r11_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && push && pop) |=> $stable(cnt_q));
  // R13: occupancy is cleared outside FIFO mode
  a_r13_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> cnt_q == '0);
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank
  import mbif_pkg::*;
#(
  parameter int NB = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [NB-1:0] buf_event,
  input  fifo_evt_t     fifo_evt,
  input  logic [NB-1:0] clr_vec,
  output logic [NB-1:0] flags_q
);
  logic [NB-1:0] set_vec, flags_d;
  logic          flag_en;

  always_comb begin
    set_vec = buf_event;
    if (fifo_en) begin
      set_vec[FIFO_LOW-1:0] = '0;
      set_vec[OVF_BIT]      = fifo_evt.ovf;
      set_vec[WARN_BIT]     = fifo_evt.warn;
      set_vec[AVAIL_BIT]    = fifo_evt.avail;
    end
  end

  always_comb begin
    flags_d = (flags_q & ~clr_vec) | set_vec;
    if (fifo_en) flags_d[DEAD_TOP:0] = '0;
  end

  assign flag_en = (flags_d != flags_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_en) flags_q <= flags_d;
  end

  // R4: a set is never lost to a clear in the same cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  // R3: a cleared flag with no set stays clear
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));
  // R7: unused low flags read zero in FIFO mode
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> flags_q[DEAD_TOP:0] == '0);
endmodule

// File: rtl/mbif_irq_ctrl.sv
module mbif_irq_ctrl
  import mbif_pkg::*;
#(
  parameter int NB         = 32,
  parameter int FIFO_DEPTH = 6,
  parameter int FIFO_WARN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              abort_en,
  input  logic [NB-1:0]     buf_event,
  input  logic [NB-1:0]     buf_is_tx,
  input  logic              fifo_push,
  input  logic              fifo_pop,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NB-1:0]     reg_wdata,
  output logic [NB-1:0]     reg_rdata,
  output logic              irq,
  output logic [NB-1:0]     wr_block
);
  logic          rst_sync_n;
  fifo_evt_t     fifo_evt;
  logic [NB-1:0] flags_q, mask_q, mask_d, clr_vec;
  logic          hit_flag, hit_mask, mask_en;

  mbif_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbif_fifo_track #(.DEPTH(FIFO_DEPTH), .WARN(FIFO_WARN)) i_fifo_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fifo_en (fifo_en),
    .push    (fifo_push),
    .pop     (fifo_pop),
    .evt     (fifo_evt)
  );

  assign hit_flag = (reg_addr == FLAG_OFS);
  assign hit_mask = (reg_addr == MASK_OFS);
  assign clr_vec  = (reg_wr && hit_flag) ? reg_wdata : '0;

  mbif_flag_bank #(.NB(NB)) i_flag_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fifo_en   (fifo_en),
    .buf_event (buf_event),
    .fifo_evt  (fifo_evt),
    .clr_vec   (clr_vec),
    .flags_q   (flags_q)
  );

  // mask register: next state and register kept apart
  assign mask_en = reg_wr && hit_mask;
  assign mask_d  = reg_wdata;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    if (hit_flag)      reg_rdata = flags_q;
    else if (hit_mask) reg_rdata = mask_q;
    else               reg_rdata = '0;
  end

  assign irq = |(flags_q & mask_q);

  // one write-block lane per buffer; low lanes belong to the FIFO in FIFO mode
  for (genvar gi = 0; gi < NB; gi++) begin : g_lane
    if (gi < FIFO_LOW) begin : g_low
      assign wr_block[gi] = abort_en && !fifo_en && buf_is_tx[gi] && flags_q[gi];
    end else begin : g_high
      assign wr_block[gi] = abort_en && buf_is_tx[gi] && flags_q[gi];
    end
  end

  // R6: no write block without abort mode
  a_r6_block_needs_abort: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|wr_block) |-> abort_en);
  // R5: a zero mask keeps the interrupt low
  a_r5_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq);
  // R12: writes to other offsets leave the mask alone
  a_r12_no_stray_mask: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && !hit_mask) |=> $stable(mask_q));
endmodule

// File: tb/test_mbif_irq_ctrl.sv
module test_mbif_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_en, abort_en, fifo_push, fifo_pop, reg_wr;
  logic [31:0] buf_event, buf_is_tx, reg_wdata, reg_rdata, wr_block;
  logic [5:0]  reg_addr;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [5:0] A_FLAG = 6'h30, A_MASK = 6'h28, A_NONE = 6'h2C;

  always #4 clk = ~clk;  // 125 MHz

  mbif_irq_ctrl i_mbif_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .abort_en(abort_en),
    .buf_event(buf_event), .buf_is_tx(buf_is_tx), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .wr_block(wr_block)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_event(input logic [31:0] e);
    buf_event = e; step(); buf_event = '0;
  endtask

  task automatic push_n(input int n);
    for (int k = 0; k < n; k++) begin fifo_push = 1'b1; step(); end
    fifo_push = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int k = 0; k < n; k++) begin fifo_pop = 1'b1; step(); end
    fifo_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_FLAG, d); check("R1 flags", d, 32'h0);
    rd(A_MASK, d); check("R1 mask", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 wr_block", wr_block, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    pulse_event(32'h8000_0101);
    rd(A_FLAG, d); check("R2 set", d, 32'h8000_0101);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, d); check("R3 write zero", d, 32'h8000_0101);
    wr(A_FLAG, 32'h0000_0100);
    rd(A_FLAG, d); check("R3 partial clear", d, 32'h8000_0001);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    buf_event = 32'h0000_0200;
    wr(A_FLAG, 32'h0000_0200);
    buf_event = '0;
    rd(A_FLAG, d); check("R4 set wins", d, 32'h0000_0200);
    wr(A_FLAG, 32'h0000_0200);
    rd(A_FLAG, d); check("R4 later clear", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pulse_event(32'h8);
    check("R5 unmasked", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h8);
    rd(A_MASK, d); check("R5 mask read", d, 32'h8);
    check("R5 irq on", {31'h0, irq}, 32'h1);
    wr(A_MASK, 32'h10);
    check("R5 other mask", {31'h0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
    wr(A_FLAG, 32'hFFFF_FFFF);
  endtask

  task automatic t_block();
    pulse_event(32'h0000_1000);
    buf_is_tx = 32'h0000_1000; #1;
    check("R6 abort off", wr_block, 32'h0);
    abort_en = 1'b1; #1;
    check("R6 blocked", wr_block, 32'h0000_1000);
    buf_is_tx = 32'h0; #1;
    check("R6 rx buffer", wr_block, 32'h0);
    buf_is_tx = 32'h0000_1000;
    wr(A_FLAG, 32'h0000_1000);
    check("R6 after clear", wr_block, 32'h0);
    abort_en = 1'b0; buf_is_tx = '0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse_event(32'h0001_0000);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, d); check("R12 read zero", d, 32'h0);
    rd(A_MASK, d); check("R12 mask kept", d, 32'h0);
    rd(A_FLAG, d); check("R12 flags kept", d, 32'h0001_0000);
    wr(A_FLAG, 32'hFFFF_FFFF);
  endtask

  task automatic t_fifo_low();
    logic [31:0] d;
    fifo_en = 1'b1;
    pulse_event(32'h0000_00FF);
    rd(A_FLAG, d); check("R7 low ignored", d, 32'h0);
  endtask

  task automatic t_fifo_fill();
    logic [31:0] d;
    push_n(1);
    rd(A_FLAG, d); check("R8 avail", d, 32'h20);
    wr(A_FLAG, 32'h20);
    rd(A_FLAG, d); check("R8 resets", d, 32'h20);
    push_n(3);
    rd(A_FLAG, d); check("R9 at four", d, 32'h20);
    push_n(1);
    rd(A_FLAG, d); check("R9 warn", d, 32'h60);
    push_n(1);
    rd(A_FLAG, d); check("R10 full no ovf", d, 32'h60);
    push_n(1);
    rd(A_FLAG, d); check("R10 overflow", d, 32'hE0);
    pop_n(6);
    wr(A_FLAG, 32'hE0);
    rd(A_FLAG, d); check("R10 saturated", d, 32'h0);
  endtask

  task automatic t_push_pop();
    logic [31:0] d;
    push_n(6);
    wr(A_FLAG, 32'h40);
    fifo_push = 1'b1; fifo_pop = 1'b1; step();
    fifo_push = 1'b0; fifo_pop = 1'b0;
    rd(A_FLAG, d); check("R11 no ovf", d, 32'h20);
    push_n(1);
    rd(A_FLAG, d); check("R11 still full", d, 32'hA0);
    pop_n(6);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, d); check("R11 drained", d, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    push_n(2);
    fifo_en = 1'b0; step();
    wr(A_FLAG, 32'hFFFF_FFFF);
    pulse_event(32'h1);
    rd(A_FLAG, d); check("R13 buffer mode", d, 32'h1);
    fifo_en = 1'b1; step();
    rd(A_FLAG, d); check("R13 count dropped", d, 32'h0);
    fifo_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; abort_en = 1'b0; fifo_push = 1'b0;
    fifo_pop = 1'b0; reg_wr = 1'b0; reg_addr = A_FLAG; reg_wdata = '0;
    buf_event = '0; buf_is_tx = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_set_clear();
    t_race();
    t_mask();
    t_block();
    t_unmapped();
    t_fifo_low();
    t_fifo_fill();
    t_push_pop();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule